// File: doc/BRIEF.md
# Four-Segment Instruction Pipeline Sequencer

This block steers instructions through four overlapping segments: instruction fetch, decode with effective-address formation, operand read, and execute with write-back. Up to four instructions are in progress at once, plus those waiting in a small prefetch queue between fetch and decode. The block tracks only control state: one valid bit and one tag per segment. The tag is the low byte of the instruction's address. Datapath values and register contents belong to the surrounding core.

One memory port is shared by instruction fetch and operand read. The port works as a request/ready handshake. `mem_req` is high while either requester wants the port, and `mem_grant_op` shows which of them owns it. An access finishes only in a cycle where `mem_ready` is high; while it is low, the owner holds. The operand read always owns the port when it needs it, so fetch yields.

A taken branch is reported during the cycle its instruction sits in execute. The block then loads the target into the fetch address, drops decode and the prefetch queue, and lets the instruction in operand read finish. An interrupt request halts fetch at once. The block waits until every segment and the queue are empty, then acknowledges and restarts fetch at the supplied vector.

Top module: `pipe4_ctrl`

## Requirements
- R1: While `rst_n` is low, the decode, operand and execute segments are empty, `retire_valid` and `irq_ack` are 0, and `fetch_addr` equals `RESET_ADDR` (0 by default).
- R2: A fetch completes (`stage_go[0]`=1) only in a cycle with `mem_ready` high and no operand read on the port; `fetch_addr` then steps by one. Without a fetch, branch or interrupt acceptance, `fetch_addr` holds its value.
- R3: Instructions retire in fetch order. `retire_tag` is the low 8 bits of the address they were fetched from. With no stall, an instruction retires 4 cycles after the cycle its fetch completed.
- R4: When the operand segment needs memory, it owns the port (`mem_grant_op`=1, `mem_req`=1), and no fetch completes in that cycle.
- R5: An instruction fetched with `instr_skip_fo`=1 passes operand read in one cycle with no memory access. With every instruction skipping and `mem_ready` held high, one instruction retires per cycle and `mem_grant_op` stays 0.
- R6: While the operand segment waits on `mem_ready` low, it does not advance (`stage_go[3]`=0), earlier segments hold, and `fetch_addr` is stable. Execute receives a bubble, so `retire_valid` is 0 in the following cycle.
- R7: Decode takes an instruction only from a non-empty prefetch queue. After a flush, `stage_go[1]` stays 0 in the flush cycle and in the cycle the target is fetched, and it rises in the cycle after that.
- R8: `br_taken` while `retire_valid` is 1 raises `flush_front` in that cycle. It loads `br_target` into `fetch_addr` for the next cycle, empties decode and the queue, and lets the instruction in operand read retire.
- R9: `irq_req` stops fetch in the same cycle. `irq_ack` pulses only once all segments and the queue are empty, after every instruction already fetched has retired. Fetch then resumes at `irq_vector` in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| mem_ready | input | 1 | Shared memory port completes the current access |
| instr_skip_fo | input | 1 | Instruction being fetched needs no operand read |
| br_taken | input | 1 | Instruction in execute redirects the flow |
| br_target | input | ADDR_W | Redirect address |
| irq_req | input | 1 | Interrupt request |
| irq_vector | input | ADDR_W | Restart address after the interrupt drain |
| mem_req | output | 1 | Some segment wants the memory port |
| mem_grant_op | output | 1 | Port owned by the operand segment |
| fetch_addr | output | ADDR_W | Address of the instruction being fetched |
| stage_go | output | 4 | Advance enables: fetch done, queue to decode, decode to operand, operand to execute |
| seg_busy | output | 4 | Valid bits: fetch requesting, decode, operand, execute |
| flush_front | output | 1 | Decode and queue are discarded this cycle |
| irq_ack | output | 1 | Interrupt accepted, fetch restarts at the vector |
| retire_valid | output | 1 | Execute holds an instruction this cycle |
| retire_tag | output | 8 | Tag of the instruction in execute |

## Verification
Two pairs of functions can fall in the same cycle. A branch can resolve while an older instruction is still in operand read. The bench steps through this by raising `br_taken` exactly in the cycle a chosen tag retires. It judges the outcome by the retire order: the operand-segment instruction must appear once, then the target, with no decoded or queued leftovers. Port contention is the second pair. The bench clears the skip flag so that operand reads and fetches compete in many consecutive cycles, and it drops `mem_ready` during an operand read. It then checks that fetch never completes alongside an operand grant and that the freeze leaves a bubble in execute.

// File: rtl/pipe4_pkg.sv
package pipe4_pkg;
  parameter int TAG_W = 8;

  typedef struct packed {
    logic [TAG_W-1:0] tag;
    logic             skip_fo;
  } slot_t;
endpackage

// File: rtl/pipe4_ibuf.sv
module pipe4_ibuf #(
  parameter int DEPTH = 4,
  parameter int W     = 9
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         push,
  input  logic [W-1:0] din,
  input  logic         pop,
  output logic [W-1:0] dout,
  output logic         empty,
  output logic         full
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [W-1:0]  store [DEPTH];
  logic [PW-1:0] wr_ptr, rd_ptr;
  logic [CW-1:0] cnt;
  logic          do_push, do_pop;

  function automatic logic [PW-1:0] step(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign empty   = (cnt == '0);
  assign full    = (cnt == CW'(DEPTH));
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;
  assign dout    = store[rd_ptr];

  always_ff @(posedge clk) begin
    if (do_push && !clr) store[wr_ptr] <= din;
  end

  always_ff @(posedge clk) begin
    if (!rst_n || clr) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      cnt    <= '0;
    end else begin
      if (do_push) wr_ptr <= step(wr_ptr);
      if (do_pop)  rd_ptr <= step(rd_ptr);
      cnt <= cnt + CW'(do_push) - CW'(do_pop);
    end
  end
endmodule

// File: rtl/pipe4_mem_arb.sv
module pipe4_mem_arb (
  input  logic op_req,
  input  logic if_req,
  input  logic mem_ready,
  output logic mem_req,
  output logic grant_op,
  output logic op_done,
  output logic if_done
);
  // Older instruction (operand read) has fixed priority over fetch.
  assign mem_req  = op_req || if_req;
  assign grant_op = op_req;
  assign op_done  = op_req && mem_ready;
  assign if_done  = if_req && !op_req && mem_ready;
endmodule

// File: rtl/pipe4_seg.sv
module pipe4_seg #(
  parameter int W = 9
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         kill,
  input  logic         en,
  input  logic         nxt_valid,
  input  logic [W-1:0] nxt_data,
  output logic         valid,
  output logic [W-1:0] data
);
  always_ff @(posedge clk) begin
    if (!rst_n || kill) begin
      valid <= 1'b0;
    end else if (en) begin
      valid <= nxt_valid;
    end
  end

  always_ff @(posedge clk) begin
    if (en && nxt_valid) data <= nxt_data;
  end
endmodule

// File: rtl/pipe4_ctrl.sv
module pipe4_ctrl
  import pipe4_pkg::*;
#(
  parameter int                ADDR_W     = 16,
  parameter int                BUF_DEPTH  = 4,
  parameter logic [ADDR_W-1:0] RESET_ADDR = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mem_ready,
  input  logic              instr_skip_fo,
  input  logic              br_taken,
  input  logic [ADDR_W-1:0] br_target,
  input  logic              irq_req,
  input  logic [ADDR_W-1:0] irq_vector,
  output logic              mem_req,
  output logic              mem_grant_op,
  output logic [ADDR_W-1:0] fetch_addr,
  output logic [3:0]        stage_go,
  output logic [3:0]        seg_busy,
  output logic              flush_front,
  output logic              irq_ack,
  output logic              retire_valid,
  output logic [TAG_W-1:0]  retire_tag
);
  localparam int NSEG   = 3;
  localparam int S_DA   = 0;
  localparam int S_FO   = 1;
  localparam int S_EX   = 2;
  localparam int SLOT_W = $bits(slot_t);

  slot_t             seg_d  [NSEG];
  slot_t             seg_nd [NSEG];
  logic [NSEG-1:0]   seg_v, seg_en, seg_nv, seg_kill;

  logic [ADDR_W-1:0] pc;
  logic              irq_pend, irq_acc, drained;
  logic              fetch_req, if_done, op_done, fo_mem;
  logic              fo_done, fo_free, da_adv, da_free, q_pop, redirect;
  logic              q_empty, q_full;
  slot_t             q_head, fetch_slot;

  // Segment registers: decode, operand read, execute
  for (genvar k = 0; k < NSEG; k++) begin : g_seg
    pipe4_seg #(.W(SLOT_W)) u_seg (
      .clk      (clk),
      .rst_n    (rst_n),
      .kill     (seg_kill[k]),
      .en       (seg_en[k]),
      .nxt_valid(seg_nv[k]),
      .nxt_data (seg_nd[k]),
      .valid    (seg_v[k]),
      .data     (seg_d[k])
    );
  end

  assign redirect = br_taken && seg_v[S_EX];
  assign fo_mem   = seg_v[S_FO] && !seg_d[S_FO].skip_fo;
  assign fo_done  = seg_v[S_FO] && (seg_d[S_FO].skip_fo || op_done);
  assign fo_free  = !seg_v[S_FO] || fo_done;
  assign da_adv   = seg_v[S_DA] && fo_free && !redirect;
  assign da_free  = !seg_v[S_DA] || da_adv;
  assign q_pop    = !q_empty && da_free && !redirect;

  assign drained   = (seg_v == '0) && q_empty;
  assign irq_acc   = irq_pend && drained;
  assign fetch_req = !irq_req && !irq_pend && !q_full && !redirect;

  always_comb begin
    seg_en[S_DA]   = da_free;
    seg_nv[S_DA]   = q_pop;
    seg_nd[S_DA]   = q_head;
    seg_kill[S_DA] = redirect;
    seg_en[S_FO]   = fo_free;
    seg_nv[S_FO]   = da_adv;
    seg_nd[S_FO]   = seg_d[S_DA];
    seg_kill[S_FO] = 1'b0;
    seg_en[S_EX]   = 1'b1;
    seg_nv[S_EX]   = fo_done;
    seg_nd[S_EX]   = seg_d[S_FO];
    seg_kill[S_EX] = 1'b0;
  end

  pipe4_mem_arb u_arb (
    .op_req   (fo_mem),
    .if_req   (fetch_req),
    .mem_ready(mem_ready),
    .mem_req  (mem_req),
    .grant_op (mem_grant_op),
    .op_done  (op_done),
    .if_done  (if_done)
  );

  always_comb begin
    fetch_slot.tag     = pc[TAG_W-1:0];
    fetch_slot.skip_fo = instr_skip_fo;
  end

  pipe4_ibuf #(.DEPTH(BUF_DEPTH), .W(SLOT_W)) u_ibuf (
    .clk  (clk),
    .rst_n(rst_n),
    .clr  (redirect),
    .push (if_done),
    .din  (fetch_slot),
    .pop  (q_pop),
    .dout (q_head),
    .empty(q_empty),
    .full (q_full)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pc       <= RESET_ADDR;
      irq_pend <= 1'b0;
    end else begin
      if (irq_acc)       pc <= irq_vector;
      else if (redirect) pc <= br_target;
      else if (if_done)  pc <= pc + 1'b1;
      if (irq_acc)       irq_pend <= 1'b0;
      else if (irq_req)  irq_pend <= 1'b1;
    end
  end

  assign fetch_addr   = pc;
  assign stage_go     = {fo_done, da_adv, q_pop, if_done};
  assign seg_busy     = {seg_v[S_EX], seg_v[S_FO], seg_v[S_DA], fetch_req};
  assign flush_front  = redirect;
  assign irq_ack      = irq_acc;
  assign retire_valid = seg_v[S_EX];
  assign retire_tag   = seg_d[S_EX].tag;
endmodule

// File: rtl/pipe4_ctrl_chk.sv
module pipe4_ctrl_chk #(
  parameter int ADDR_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              mem_grant_op,
  input logic [3:0]        stage_go,
  input logic [2:0]        busy_hi,
  input logic              retire_valid,
  input logic              flush_front,
  input logic              irq_req,
  input logic              irq_ack,
  input logic [ADDR_W-1:0] fetch_addr,
  input logic [ADDR_W-1:0] br_target,
  input logic [ADDR_W-1:0] irq_vector
);
  a_r4_port_single: assert property (@(posedge clk) disable iff (!rst_n)
    mem_grant_op |-> !stage_go[0]);

  a_r3_exec_feed: assert property (@(posedge clk) disable iff (!rst_n)
    stage_go[3] |=> retire_valid);

  a_r6_bubble: assert property (@(posedge clk) disable iff (!rst_n)
    !stage_go[3] |=> !retire_valid);

  a_r2_addr_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!stage_go[0] && !flush_front && !irq_ack) |=> $stable(fetch_addr));

  a_r8_front_cleared: assert property (@(posedge clk) disable iff (!rst_n)
    flush_front |=> !busy_hi[0]);

  a_r8_target: assert property (@(posedge clk) disable iff (!rst_n)
    flush_front |=> (fetch_addr == $past(br_target)));

  a_r9_fetch_halt: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req |-> !stage_go[0]);

  a_r9_empty_at_ack: assert property (@(posedge clk) disable iff (!rst_n)
    irq_ack |-> (busy_hi == 3'b000));

  a_r9_vector: assert property (@(posedge clk) disable iff (!rst_n)
    irq_ack |=> (fetch_addr == $past(irq_vector)));
endmodule

bind pipe4_ctrl pipe4_ctrl_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .mem_grant_op(mem_grant_op),
  .stage_go    (stage_go),
  .busy_hi     (seg_busy[3:1]),
  .retire_valid(retire_valid),
  .flush_front (flush_front),
  .irq_req     (irq_req),
  .irq_ack     (irq_ack),
  .fetch_addr  (fetch_addr),
  .br_target   (br_target),
  .irq_vector  (irq_vector)
);

// File: tb/pipe4_ctrl_tb.sv
`timescale 1ns/1ps
module pipe4_ctrl_tb;
  localparam int AW = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          mem_ready = 1'b1;
  logic          instr_skip_fo = 1'b1;
  logic          br_taken = 1'b0;
  logic [AW-1:0] br_target = '0;
  logic          irq_req = 1'b0;
  logic [AW-1:0] irq_vector = '0;
  logic          mem_req, mem_grant_op, flush_front, irq_ack, retire_valid;
  logic [AW-1:0] fetch_addr;
  logic [3:0]    stage_go, seg_busy;
  logic [7:0]    retire_tag;

  int checks = 0;
  int errors = 0;
  int retired = 0;
  bit done = 1'b0;
  logic [7:0] sb_q[$];

  always #4 clk = ~clk;

  pipe4_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .mem_ready(mem_ready), .instr_skip_fo(instr_skip_fo),
    .br_taken(br_taken), .br_target(br_target), .irq_req(irq_req), .irq_vector(irq_vector),
    .mem_req(mem_req), .mem_grant_op(mem_grant_op), .fetch_addr(fetch_addr),
    .stage_go(stage_go), .seg_busy(seg_busy), .flush_front(flush_front),
    .irq_ack(irq_ack), .retire_valid(retire_valid), .retire_tag(retire_tag)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // Sample point: 2 ns after the falling edge; drivers also act here.
  task automatic tick();
    @(negedge clk);
    #2;
  endtask

  // Scoreboard: fetch tap pushes expected tags, retire monitor pops them.
  always begin
    @(negedge clk);
    #3;
    if (rst_n && !done) begin
      if (retire_valid) begin
        retired++;
        if (sb_q.size() == 0) begin
          chk(1'b0, "R3", "unexpected retire", retire_tag, 0);
        end else begin
          logic [7:0] exp_tag;
          exp_tag = sb_q.pop_front();
          chk(retire_tag == exp_tag, "R3", "retire order tag", retire_tag, exp_tag);
        end
      end
      if (flush_front) begin
        // R8: only the operand-segment instruction survives a redirect
        int keep;
        keep = seg_busy[2] ? 1 : 0;
        while (sb_q.size() > keep) void'(sb_q.pop_back());
      end
      if (stage_go[0]) sb_q.push_back(fetch_addr[7:0]);
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      errors++;
      $display("FAIL watchdog: actual %0d expected %0d", 200000, 0);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [AW-1:0] held;
    int misses;
    int overlap;
    int grants;
    bit seen;

    // R1 reset state
    repeat (3) tick();
    chk(seg_busy[3:1] == 3'b000, "R1", "segments empty", seg_busy, 0);
    chk(!retire_valid && !irq_ack, "R1", "retire/ack low", {retire_valid, irq_ack}, 0);
    chk(fetch_addr == 16'h0000, "R1", "fetch_addr", fetch_addr, 0);

    // R2 first fetch, then R3 latency
    @(negedge clk);
    rst_n = 1'b1;
    #2;
    chk(stage_go[0] && fetch_addr == 0, "R2", "first fetch at 0", {stage_go[0], fetch_addr}, 1 << 16);
    tick();
    chk(fetch_addr == 16'h0001, "R2", "address steps", fetch_addr, 1);
    tick();
    tick();
    chk(!retire_valid, "R3", "nothing retired at cycle 3", retire_valid, 0);
    tick();
    chk(retire_valid && retire_tag == 8'h00, "R3", "first retire at cycle 4", {retire_valid, retire_tag}, 9'h100);

    // R5 all-skip stream: one retire per cycle, no operand grants
    misses = 0;
    for (int i = 0; i < 10; i++) begin
      tick();
      if (!retire_valid || mem_grant_op) misses++;
    end
    chk(misses == 0, "R5", "full-rate skip stream", misses, 0);

    // R8 branch while an older instruction sits in operand read
    seen = 1'b0;
    for (int i = 0; i < 100 && !seen; i++) begin
      tick();
      if (retire_valid && retire_tag == 8'd20) seen = 1'b1;
    end
    chk(seen, "R8", "reached tag 20", seen, 1);
    br_target = 16'h0040;
    br_taken  = 1'b1;
    #0.5;
    chk(flush_front, "R8", "flush raised", flush_front, 1);
    chk(!stage_go[1], "R7", "no decode in flush cycle", stage_go[1], 0);
    @(negedge clk);
    br_taken = 1'b0;
    #2;
    chk(fetch_addr == 16'h0040 && stage_go[0], "R8", "fetch at target", fetch_addr, 16'h0040);
    chk(!stage_go[1], "R7", "decode waits on empty queue", stage_go[1], 0);
    chk(retire_valid && retire_tag == 8'd21, "R8", "operand instr completes", retire_tag, 21);
    tick();
    chk(stage_go[1], "R7", "decode takes target", stage_go[1], 1);

    // R4 / R6 contention: instructions now need an operand read
    @(negedge clk);
    instr_skip_fo = 1'b0;
    seen = 1'b0;
    for (int i = 0; i < 40 && !seen; i++) begin
      tick();
      if (mem_grant_op) seen = 1'b1;
    end
    chk(seen && mem_req && !stage_go[0], "R4", "operand owns port, fetch held",
        {seen, mem_req, stage_go[0]}, 3'b110);
    held = fetch_addr;
    mem_ready = 1'b0;
    #0.5;
    chk(!stage_go[3], "R6", "operand waits on ready", stage_go[3], 0);
    for (int i = 0; i < 3; i++) begin
      tick();
      chk(!retire_valid, "R6", "bubble in execute", retire_valid, 0);
      chk(stage_go == 4'b0000 && fetch_addr == held, "R6", "front held",
          {stage_go, fetch_addr}, {4'b0000, held});
    end
    mem_ready = 1'b1;
    overlap = 0;
    grants = 0;
    for (int i = 0; i < 20; i++) begin
      tick();
      if (mem_grant_op) grants++;
      if (mem_grant_op && stage_go[0]) overlap++;
    end
    chk(overlap == 0 && grants > 0, "R4", "no fetch during operand grant", overlap, 0);

    // R9 interrupt drain
    @(negedge clk);
    instr_skip_fo = 1'b1;
    repeat (8) tick();
    irq_vector = 16'h0080;
    irq_req = 1'b1;
    #0.5;
    chk(!stage_go[0], "R9", "fetch halts with request", stage_go[0], 0);
    @(negedge clk);
    irq_req = 1'b0;
    #2;
    seen = 1'b0;
    for (int i = 0; i < 40 && !seen; i++) begin
      if (irq_ack) seen = 1'b1;
      else tick();
    end
    chk(seen, "R9", "ack raised", seen, 1);
    chk(seg_busy[3:1] == 3'b000, "R9", "pipe empty at ack", seg_busy, 0);
    chk(sb_q.size() == 0, "R9", "all fetched retired", sb_q.size(), 0);
    tick();
    chk(fetch_addr == 16'h0080 && stage_go[0], "R9", "restart at vector", fetch_addr, 16'h0080);
    repeat (12) tick();
    chk(retired > 40, "R3", "retire count", retired, 41);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule